// File: doc/BRIEF.md
# Floating-Point Status Word and Exception Trap Unit

This block owns the control and status word of a floating-point unit. Two fields of the word are decoded continuously into controls for the arithmetic datapath: a rounding-mode selector and a denormal flush control. Each time the datapath finishes an operation, it sends a completion strobe with a five-bit vector of the exceptions that operation raised. The unit ORs that vector into sticky flag bits in the word. If any raised exception has its enable bit set, the unit requests an assist trap.

Software loads and reads the whole word through a register-file style port. A load takes effect at once: the rounding and flush controls are decoded again from the new word on the next cycle. Flags stay set until software writes the word again. An operation that raises nothing leaves the word untouched.

Top module: `fp_status_trap_unit`

## Requirements
- R1: The rounding field at word bits [17:16] drives the one-hot output rnd_sel_o: value 0 sets bit 0 (nearest even), 1 sets bit 1 (toward zero), 2 sets bit 2 (toward +infinity) and 3 sets bit 3 (toward -infinity).
- R2: Word bit 20 is the denormal control, and it drives both flush_res_o (results) and flush_in_o (inputs) with the same value.
- R3: The exception vector index is 0 inexact, 1 underflow, 2 overflow, 3 divide-by-zero, 4 invalid. Enable bit i sits at word bit i, and flag bit i sits at word bit 8+i.
- R4: On a cycle with op_done_i high and no software write, op_exc_i is ORed into the flags, and the new word is visible on sw_rdata_o in the next cycle. Flags that are already set are never cleared by an operation.
- R5: When op_done_i is high with op_exc_i zero, the word is unchanged. op_exc_i has no effect while op_done_i is low.
- R6: trap_o is high for exactly the cycle after an operation-done cycle in which some bit of op_exc_i has its enable set. In every other cycle trap_o is low.
- R7: A software write stores the full 32-bit word, which is returned on sw_rdata_o from the next cycle. The rounding and flush outputs follow the written value from that same cycle.
- R8: Reset clears the word, which gives round to nearest, no flush, all enables and flags off, and trap_o low.
- R9: When a software write and an operation completion occur in the same cycle, the written value is stored as it is, the operation's exceptions are discarded, and no trap is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sw_we_i | input | 1 | Software load strobe for the status word |
| sw_wdata_i | input | 32 | Word value to load |
| sw_rdata_o | output | 32 | Current status word |
| op_done_i | input | 1 | Datapath operation completed this cycle |
| op_exc_i | input | 5 | Exceptions raised by the completed operation |
| rnd_sel_o | output | 4 | One-hot rounding-mode select |
| flush_res_o | output | 1 | Flush denormal results to zero |
| flush_in_o | output | 1 | Flush denormal inputs to zero |
| trap_o | output | 1 | Assist trap request pulse |

## Verification
The hardest case to reach is a cycle where a software load and an operation completion arrive together. In that case the operation's exceptions must disappear: no flags are merged and no trap is raised, even when the operation would have trapped under both the old word and the new one. The stimulus sets an enable, then drives the write and the done strobe in the same cycle with a matching exception, so the only correct result is the written word and a quiet trap line. Each exception class is also sent on its own with only its own enable set, which confirms that flags and enables are paired bit for bit.

// File: rtl/fpst_pkg.sv
package fpst_pkg;
  localparam int unsigned WORD_W    = 32;
  localparam int unsigned NUM_EXC   = 5;
  localparam int unsigned ENA_LSB   = 0;
  localparam int unsigned FLAG_LSB  = 8;
  localparam int unsigned RND_LSB   = 16;
  localparam int unsigned FLUSH_BIT = 20;
  localparam int unsigned RND_W     = 2;
  localparam int unsigned NUM_RND   = 1 << RND_W;

  typedef enum logic [RND_W-1:0] {
    RND_NEAREST = 2'd0,
    RND_ZERO    = 2'd1,
    RND_POS     = 2'd2,
    RND_NEG     = 2'd3
  } rnd_mode_e;
endpackage

// File: rtl/fpst_ctrl_decode.sv
module fpst_ctrl_decode
  import fpst_pkg::*;
(
  input  logic [RND_W-1:0]   rnd_field_i,
  input  logic               flush_bit_i,
  output logic [NUM_RND-1:0] rnd_sel_o,
  output logic               flush_res_o,
  output logic               flush_in_o
);
  rnd_mode_e mode;
  assign mode = rnd_mode_e'(rnd_field_i);

  for (genvar g = 0; g < NUM_RND; g++) begin : g_rnd
    assign rnd_sel_o[g] = (mode == rnd_mode_e'(g));
  end

  // one control bit gates both flush paths
  assign flush_res_o = flush_bit_i;
  assign flush_in_o  = flush_bit_i;
endmodule

// File: rtl/fpst_exc_merge.sv
module fpst_exc_merge #(
  parameter int unsigned NUM_EXC = 5
) (
  input  logic [NUM_EXC-1:0] exc_i,
  input  logic [NUM_EXC-1:0] ena_i,
  input  logic [NUM_EXC-1:0] flags_i,
  output logic [NUM_EXC-1:0] flags_o,
  output logic               hit_o
);
  logic [NUM_EXC-1:0] hit_vec;

  for (genvar g = 0; g < NUM_EXC; g++) begin : g_exc
    assign flags_o[g] = flags_i[g] | exc_i[g];
    assign hit_vec[g] = exc_i[g] & ena_i[g];
  end

  assign hit_o = |hit_vec;
endmodule

// File: rtl/fpst_word_reg.sv
module fpst_word_reg #(
  parameter int unsigned WORD_W   = 32,
  parameter int unsigned NUM_EXC  = 5,
  parameter int unsigned FLAG_LSB = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic              upd_i,
  input  logic [WORD_W-1:0] upd_data_i,
  output logic [WORD_W-1:0] word_o
);
  logic [WORD_W-1:0] word_q;

  // software write has priority over an operation update
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      word_q <= '0;
    else if (we_i)    word_q <= wdata_i;
    else if (upd_i)   word_q <= upd_data_i;
  end

  assign word_o = word_q;

  p_write_wins_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> word_q == $past(wdata_i));

  p_flags_sticky_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> (word_q[FLAG_LSB+:NUM_EXC] & $past(word_q[FLAG_LSB+:NUM_EXC]))
              == $past(word_q[FLAG_LSB+:NUM_EXC]));

  p_idle_stable_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!we_i && !upd_i) |=> $stable(word_q));
endmodule

// File: rtl/fp_status_trap_unit.sv
module fp_status_trap_unit
  import fpst_pkg::*;
#(
  parameter int unsigned P_WORD_W   = fpst_pkg::WORD_W,
  parameter int unsigned P_NUM_EXC  = fpst_pkg::NUM_EXC,
  parameter int unsigned P_ENA_LSB  = fpst_pkg::ENA_LSB,
  parameter int unsigned P_FLAG_LSB = fpst_pkg::FLAG_LSB
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 sw_we_i,
  input  logic [P_WORD_W-1:0]  sw_wdata_i,
  output logic [P_WORD_W-1:0]  sw_rdata_o,
  input  logic                 op_done_i,
  input  logic [P_NUM_EXC-1:0] op_exc_i,
  output logic [NUM_RND-1:0]   rnd_sel_o,
  output logic                 flush_res_o,
  output logic                 flush_in_o,
  output logic                 trap_o
);
  logic [P_WORD_W-1:0]  word;
  logic [P_WORD_W-1:0]  upd_word;
  logic [P_NUM_EXC-1:0] new_flags;
  logic                 hit;
  logic                 upd;
  logic                 trap_q;

  fpst_ctrl_decode u_dec (
    .rnd_field_i (word[RND_LSB+:RND_W]),
    .flush_bit_i (word[FLUSH_BIT]),
    .rnd_sel_o   (rnd_sel_o),
    .flush_res_o (flush_res_o),
    .flush_in_o  (flush_in_o)
  );

  fpst_exc_merge #(.NUM_EXC(P_NUM_EXC)) u_merge (
    .exc_i   (op_exc_i),
    .ena_i   (word[P_ENA_LSB+:P_NUM_EXC]),
    .flags_i (word[P_FLAG_LSB+:P_NUM_EXC]),
    .flags_o (new_flags),
    .hit_o   (hit)
  );

  always_comb begin
    upd_word = word;
    upd_word[P_FLAG_LSB+:P_NUM_EXC] = new_flags;
  end

  // a clean completion writes nothing
  assign upd = op_done_i & (|op_exc_i);

  fpst_word_reg #(
    .WORD_W   (P_WORD_W),
    .NUM_EXC  (P_NUM_EXC),
    .FLAG_LSB (P_FLAG_LSB)
  ) u_reg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (sw_we_i),
    .wdata_i    (sw_wdata_i),
    .upd_i      (upd),
    .upd_data_i (upd_word),
    .word_o     (word)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) trap_q <= 1'b0;
    else         trap_q <= op_done_i & ~sw_we_i & hit;
  end

  assign trap_o     = trap_q;
  assign sw_rdata_o = word;

  p_trap_cause_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_o |-> $past(op_done_i && !sw_we_i));

  p_trap_taken_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_done_i && !sw_we_i && |(op_exc_i & sw_rdata_o[P_ENA_LSB+:P_NUM_EXC])) |=> trap_o);

  p_collide_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_we_i |=> !trap_o);

  p_flush_follows_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_we_i |=> (flush_res_o == $past(sw_wdata_i[FLUSH_BIT])) && (flush_in_o == flush_res_o));
endmodule

// File: tb/fp_status_trap_unit_test.sv
`timescale 1ns/1ps
module fp_status_trap_unit_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        sw_we_i = 1'b0;
  logic [31:0] sw_wdata_i = '0;
  logic [31:0] sw_rdata_o;
  logic        op_done_i = 1'b0;
  logic [4:0]  op_exc_i = '0;
  logic [3:0]  rnd_sel_o;
  logic        flush_res_o, flush_in_o, trap_o;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;
  logic [31:0] word_m = '0;

  typedef struct {
    logic [31:0] word;
    logic        trap;
    logic [3:0]  rnd;
    logic        flush;
    string       tag;
  } exp_t;
  exp_t exp_q[$];

  always #2.5 clk_i = ~clk_i;

  fp_status_trap_unit uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .sw_we_i(sw_we_i), .sw_wdata_i(sw_wdata_i),
    .sw_rdata_o(sw_rdata_o), .op_done_i(op_done_i), .op_exc_i(op_exc_i),
    .rnd_sel_o(rnd_sel_o), .flush_res_o(flush_res_o), .flush_in_o(flush_in_o),
    .trap_o(trap_o)
  );

  function automatic void compare(exp_t e);
    compared++;
    if (sw_rdata_o !== e.word || trap_o !== e.trap || rnd_sel_o !== e.rnd ||
        flush_res_o !== e.flush || flush_in_o !== e.flush) begin
      mismatched++;
      $display("FAIL %s: word=%h trap=%b rnd=%b flush=%b%b expected word=%h trap=%b rnd=%b flush=%b",
               e.tag, sw_rdata_o, trap_o, rnd_sel_o, flush_res_o, flush_in_o,
               e.word, e.trap, e.rnd, e.flush);
    end
  endfunction

  // driver: apply one cycle of stimulus, predict the result
  task automatic step(input bit we, input logic [31:0] wd, input bit done,
                      input logic [4:0] exc, input string tag);
    exp_t e;
    sw_we_i = we; sw_wdata_i = wd; op_done_i = done; op_exc_i = exc;
    e.trap = 1'b0;
    if (we) word_m = wd;
    else if (done) begin
      e.trap = |(exc & word_m[4:0]);
      word_m[12:8] = word_m[12:8] | exc;
    end
    e.word = word_m;
    e.rnd = 4'b0001 << word_m[17:16];
    e.flush = word_m[20];
    e.tag = tag;
    exp_q.push_back(e);
    @(negedge clk_i);
  endtask

  task automatic idle(input string tag);
    step(1'b0, 32'h0, 1'b0, 5'h0, tag);
  endtask

  // monitor: compare one predicted item per clock, after the edge settles
  initial begin
    forever begin
      @(posedge clk_i);
      #1;
      if (exp_q.size() > 0) compare(exp_q.pop_front());
    end
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    exp_t r;
    repeat (3) @(negedge clk_i);
    // R8: reset state
    r.word = '0; r.trap = 1'b0; r.rnd = 4'b0001; r.flush = 1'b0; r.tag = "R8 reset";
    compare(r);
    rst_ni = 1'b1;
    @(negedge clk_i);
    idle("R8 idle after reset");

    // R1 / R7: each rounding mode, full word read back
    for (int m = 0; m < 4; m++) begin
      logic [31:0] w;
      w = 32'hA5A0_0000 | (32'(m) << 16);
      step(1'b1, w, 1'b0, 5'h0, "R1 rounding decode");
    end
    step(1'b1, 32'h1234_0000, 1'b0, 5'h0, "R7 word load");
    // R2: flush bit drives both outputs
    step(1'b1, 32'h0010_0000, 1'b0, 5'h0, "R2 flush on");
    step(1'b1, 32'h0000_0000, 1'b0, 5'h0, "R2 flush off");

    // R4: flags merge, no enables so no trap
    step(1'b0, 32'h0, 1'b1, 5'b00101, "R4 merge flags");
    step(1'b0, 32'h0, 1'b1, 5'b10000, "R4 sticky merge");
    // R5: clean completion and ignored exc without done
    step(1'b0, 32'h0, 1'b1, 5'b00000, "R5 clean op");
    step(1'b0, 32'h0, 1'b0, 5'b11111, "R5 exc without done");
    idle("R5 still unchanged");

    // R6: enable overflow only
    step(1'b1, 32'h0000_0004, 1'b0, 5'h0, "R6 set overflow enable");
    step(1'b0, 32'h0, 1'b1, 5'b00100, "R6 trap on overflow");
    idle("R6 trap is one pulse");
    step(1'b0, 32'h0, 1'b1, 5'b00001, "R6 disabled class no trap");
    step(1'b0, 32'h0, 1'b1, 5'b00100, "R6 trap with flag already set");
    step(1'b0, 32'h0, 1'b1, 5'b00100, "R6 back to back trap");
    idle("R6 trap drops");

    // R3: each class paired with its own enable
    for (int i = 0; i < 5; i++) begin
      step(1'b1, 32'(1) << i, 1'b0, 5'h0, "R3 load single enable");
      step(1'b0, 32'h0, 1'b1, 5'(1) << i, "R3 matching class traps");
      step(1'b0, 32'h0, 1'b1, 5'(1) << ((i + 1) % 5), "R3 other class quiet");
    end

    // R9: write and trapping op collide
    step(1'b1, 32'h0000_001F, 1'b0, 5'h0, "R9 enable all");
    step(1'b1, 32'h0003_001F, 1'b1, 5'b11111, "R9 write wins");
    idle("R9 no late trap");
    // R4: only a write clears flags
    step(1'b0, 32'h0, 1'b1, 5'b01000, "R4 set divzero flag");
    step(1'b1, 32'h0000_0000, 1'b0, 5'h0, "R4 write clears flags");
    idle("R8 final idle");
    @(negedge clk_i);
    @(negedge clk_i);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule